// File: doc/BRIEF.md
# Virtual Channel Priority Steering Arbiter

This block joins a link-side packet interface that carries four virtual channels (VCs) to two pairs of local streaming ports. One pair is high priority and the other is low priority. On the receive side, each incoming packet goes to the high-priority or the low-priority output stream according to its VC. Packets on a VC that is switched off are discarded, and a sticky flag records that this happened. On the transmit side, each local input has its packets tagged with a VC. The block then arbitrates among the VCs onto the single link-side output. Arbitration is either strict priority or round-robin.

A four-bit enable mask and a mode bit set the behaviour. Bit i of the mask enables VC i. The highest enabled VC always belongs to the high-priority pair. The block keeps an internal shadow copy of the configuration and refreshes it only while no packet is in flight. This means a packet never sees its routing change halfway through. Arbitration decisions are taken only at packet boundaries, which the last-beat signals mark.

Top module: `vc_steer_arb`

## Requirements
- R1: A receive beat whose VC equals the highest enabled VC is presented on hi_out (hi_out_valid=1) and never on lo_out.
- R2: A receive beat on any other enabled VC is presented on lo_out, with its VC number copied to lo_out_vc.
- R3: A receive beat on a disabled VC is accepted (rx_ready=1) and discarded. This includes every VC when the mask is all zero. The beat sets rx_drop_err, which stays at 1 until reset.
- R4: rx_ready follows only the ready of the output the beat is routed to. A low lo_out_ready never stalls traffic on the highest enabled VC.
- R5: Packets from hi_in are sent with tx_vc equal to the highest enabled VC.
- R6: Packets from lo_in keep lo_in_vc when that VC is enabled and is not the highest enabled VC. Otherwise they take the highest enabled VC below the highest. If no such VC exists, they take VC 0.
- R7: In strict mode (cfg_rr_mode=0), when both inputs are valid at a packet boundary, the input on the higher VC wins, which is hi_in.
- R8: In round-robin mode (cfg_rr_mode=1), the search starts at the VC after the one last granted and skips VCs with no request. Two inputs that request continuously (hi on VC 3, lo on VC 1) are granted VC 1, 3, 1, 3 after reset.
- R9: After the first beat of a transmit packet is accepted, the output stays with that input and that tx_vc until its last beat is accepted. During that time the other input sees ready low, and the two ready outputs are never high together.
- R10: A configuration change is copied into the shadow at a clock edge only when no receive or transmit packet is in flight. It therefore takes effect one cycle after the last beat's edge when a packet was open, and one cycle after the change otherwise.
- R11: With an all-zero mask, tx_valid, hi_in_ready and lo_in_ready are all low.
- R12: After reset, all output valids and rx_drop_err are low, the shadow mask is zero, and the round-robin search starts at VC 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_vc_en | input | NUM_VC | VC enable mask, bit i enables VC i |
| cfg_rr_mode | input | 1 | 0 strict priority, 1 round-robin |
| rx_valid | input | 1 | Link receive beat valid |
| rx_ready | output | 1 | Link receive beat accepted |
| rx_vc | input | VC_W | VC of the receive beat |
| rx_data | input | DATA_W | Receive payload |
| rx_last | input | 1 | Last beat of the receive packet |
| hi_out_valid | output | 1 | High-priority output valid |
| hi_out_ready | input | 1 | High-priority output ready |
| hi_out_data | output | DATA_W | High-priority output payload |
| hi_out_last | output | 1 | High-priority output last beat |
| lo_out_valid | output | 1 | Low-priority output valid |
| lo_out_ready | input | 1 | Low-priority output ready |
| lo_out_data | output | DATA_W | Low-priority output payload |
| lo_out_vc | output | VC_W | VC of the low-priority beat |
| lo_out_last | output | 1 | Low-priority output last beat |
| hi_in_valid | input | 1 | High-priority input valid |
| hi_in_ready | output | 1 | High-priority input accepted |
| hi_in_data | input | DATA_W | High-priority input payload |
| hi_in_last | input | 1 | High-priority input last beat |
| lo_in_valid | input | 1 | Low-priority input valid |
| lo_in_ready | output | 1 | Low-priority input accepted |
| lo_in_data | input | DATA_W | Low-priority input payload |
| lo_in_vc | input | VC_W | Requested VC for the low-priority input |
| lo_in_last | input | 1 | Low-priority input last beat |
| tx_valid | output | 1 | Link transmit beat valid |
| tx_ready | input | 1 | Link transmit beat accepted |
| tx_data | output | DATA_W | Transmit payload |
| tx_vc | output | VC_W | VC tag of the transmit beat |
| tx_last | output | 1 | Last beat of the transmit packet |
| rx_drop_err | output | 1 | Sticky flag: a beat on a disabled VC was dropped |

## Verification
- A stale or wrong shadow mask shows up in the same cycle as a beat on the wrong output or a wrong tx_vc tag. If the shadow is updated while a packet is open, the tag changes between two beats of one packet.
- A lost packet lock lets the other input's ready rise before the last beat has been accepted, and this is visible on the next beat.
- A wrong round-robin pointer appears as a repeated grant on the very next packet boundary.
- A lost sticky flag appears as rx_drop_err falling one cycle after it was set.

// File: rtl/vc_steer_pkg.sv
package vc_steer_pkg;
   typedef enum logic {
      ARB_STRICT = 1'b0,
      ARB_RR     = 1'b1
   } arb_mode_e;
endpackage

// File: rtl/vc_cfg_shadow.sv
module vc_cfg_shadow
   import vc_steer_pkg::*;
#(
   parameter int NUM_VC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_VC-1:0] cfg_en,
   input  logic              cfg_rr,
   input  logic              busy,
   output logic [NUM_VC-1:0] act_en,
   output arb_mode_e         act_mode
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_en   <= '0;
         act_mode <= ARB_STRICT;
      end else if (!busy) begin
         act_en   <= cfg_en;
         act_mode <= arb_mode_e'(cfg_rr);
      end
   end
endmodule

// File: rtl/vc_prio_calc.sv
module vc_prio_calc #(
   parameter int NUM_VC = 4,
   localparam int VC_W = $clog2(NUM_VC)
) (
   input  logic [NUM_VC-1:0] act_en,
   input  logic [VC_W-1:0]   lo_req_vc,
   output logic              top_ok,
   output logic [VC_W-1:0]   top_vc,
   output logic [VC_W-1:0]   lo_vc
);
   always_comb begin
      top_ok = 1'b0;
      top_vc = '0;
      for (int i = 0; i < NUM_VC; i++) begin
         if (act_en[i]) begin
            top_ok = 1'b1;
            top_vc = VC_W'(i);
         end
      end
   end

   always_comb begin
      lo_vc = '0;
      if (act_en[lo_req_vc] && lo_req_vc != top_vc) begin
         lo_vc = lo_req_vc;
      end else begin
         for (int i = 0; i < NUM_VC; i++) begin
            if (act_en[i] && VC_W'(i) < top_vc) lo_vc = VC_W'(i);
         end
      end
   end
endmodule

// File: rtl/vc_rx_router.sv
module vc_rx_router #(
   parameter int NUM_VC = 4,
   localparam int VC_W = $clog2(NUM_VC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_VC-1:0] act_en,
   input  logic              top_ok,
   input  logic [VC_W-1:0]   top_vc,
   input  logic              rx_valid,
   input  logic [VC_W-1:0]   rx_vc,
   input  logic              rx_last,
   output logic              rx_ready,
   output logic              hi_valid,
   input  logic              hi_ready,
   output logic              lo_valid,
   input  logic              lo_ready,
   output logic              rx_mid,
   output logic              drop_err
);
   logic to_hi, to_lo, to_drop, rx_acc;

   always_comb begin
      to_hi   = top_ok && (rx_vc == top_vc);
      to_lo   = top_ok && act_en[rx_vc] && !to_hi;
      to_drop = !to_hi && !to_lo;
   end

   assign hi_valid = rx_valid && to_hi;
   assign lo_valid = rx_valid && to_lo;
   assign rx_ready = to_hi ? hi_ready : (to_lo ? lo_ready : 1'b1);
   assign rx_acc   = rx_valid && rx_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_mid   <= 1'b0;
         drop_err <= 1'b0;
      end else begin
         if (rx_acc) rx_mid <= !rx_last;
         if (rx_valid && to_drop) drop_err <= 1'b1;
      end
   end
endmodule

// File: rtl/vc_tx_arbiter.sv
module vc_tx_arbiter
   import vc_steer_pkg::*;
#(
   parameter int NUM_VC   = 4,
   parameter bit ALLOW_RR = 1'b1,
   localparam int VC_W = $clog2(NUM_VC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  arb_mode_e       act_mode,
   input  logic            top_ok,
   input  logic [VC_W-1:0] hi_vc,
   input  logic [VC_W-1:0] lo_vc,
   input  logic            hi_valid,
   input  logic            lo_valid,
   input  logic            tx_ready,
   output logic            cur_lo,
   output logic [VC_W-1:0] cur_vc,
   output logic            tx_valid,
   output logic            hi_ready,
   output logic            lo_ready,
   input  logic            tx_last,
   output logic            locked
);
   logic            own_lo;
   logic [VC_W-1:0] own_vc;
   logic [VC_W-1:0] rr_ptr;
   logic [NUM_VC-1:0] req;
   logic            strict_lo, rr_lo, pick_lo;

   always_comb begin
      req = '0;
      if (top_ok) begin
         if (hi_valid) req[hi_vc] = 1'b1;
         if (lo_valid) req[lo_vc] = 1'b1;
      end
   end

   assign strict_lo = lo_valid && !(hi_valid && hi_vc >= lo_vc);

   generate
      if (ALLOW_RR) begin : g_rr
         logic            found;
         logic [VC_W-1:0] win_vc;
         always_comb begin
            found  = 1'b0;
            win_vc = '0;
            for (int k = 0; k < NUM_VC; k++) begin
               if (!found && req[rr_ptr + VC_W'(k)]) begin
                  found  = 1'b1;
                  win_vc = rr_ptr + VC_W'(k);
               end
            end
            rr_lo = found && lo_valid && (win_vc == lo_vc) &&
                    !(hi_valid && hi_vc == win_vc);
         end
      end else begin : g_strict_only
         assign rr_lo = strict_lo;
      end
   endgenerate

   assign pick_lo  = (act_mode == ARB_RR) ? rr_lo : strict_lo;
   assign cur_lo   = locked ? own_lo : pick_lo;
   assign cur_vc   = locked ? own_vc : (cur_lo ? lo_vc : hi_vc);
   assign tx_valid = top_ok && (cur_lo ? lo_valid : hi_valid);
   assign hi_ready = top_ok && !cur_lo && tx_ready;
   assign lo_ready = top_ok && cur_lo && tx_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked <= 1'b0;
         own_lo <= 1'b0;
         own_vc <= '0;
         rr_ptr <= '0;
      end else if (tx_valid && tx_ready) begin
         if (tx_last) begin
            locked <= 1'b0;
            rr_ptr <= cur_vc + 1'b1;
         end else begin
            locked <= 1'b1;
            own_lo <= cur_lo;
            own_vc <= cur_vc;
         end
      end
   end
endmodule

// File: rtl/vc_steer_arb.sv
module vc_steer_arb
   import vc_steer_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_VC   = 4,
   parameter bit ALLOW_RR = 1'b1,
   localparam int VC_W = $clog2(NUM_VC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_VC-1:0] cfg_vc_en,
   input  logic              cfg_rr_mode,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [VC_W-1:0]   rx_vc,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_last,
   output logic              hi_out_valid,
   input  logic              hi_out_ready,
   output logic [DATA_W-1:0] hi_out_data,
   output logic              hi_out_last,
   output logic              lo_out_valid,
   input  logic              lo_out_ready,
   output logic [DATA_W-1:0] lo_out_data,
   output logic [VC_W-1:0]   lo_out_vc,
   output logic              lo_out_last,
   input  logic              hi_in_valid,
   output logic              hi_in_ready,
   input  logic [DATA_W-1:0] hi_in_data,
   input  logic              hi_in_last,
   input  logic              lo_in_valid,
   output logic              lo_in_ready,
   input  logic [DATA_W-1:0] lo_in_data,
   input  logic [VC_W-1:0]   lo_in_vc,
   input  logic              lo_in_last,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [DATA_W-1:0] tx_data,
   output logic [VC_W-1:0]   tx_vc,
   output logic              tx_last,
   output logic              rx_drop_err
);
   generate
      if (NUM_VC < 2 || (1 << VC_W) != NUM_VC) begin : g_bad_vc
         $error("NUM_VC must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_w
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [NUM_VC-1:0] act_en;
   arb_mode_e         act_mode;
   logic              top_ok;
   logic [VC_W-1:0]   top_vc, lo_tag;
   logic              rx_mid, tx_locked, sel_lo;

   vc_cfg_shadow #(.NUM_VC(NUM_VC)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_vc_en), .cfg_rr(cfg_rr_mode),
      .busy(rx_mid || tx_locked), .act_en(act_en), .act_mode(act_mode)
   );

   vc_prio_calc #(.NUM_VC(NUM_VC)) u_prio (
      .act_en(act_en), .lo_req_vc(lo_in_vc),
      .top_ok(top_ok), .top_vc(top_vc), .lo_vc(lo_tag)
   );

   vc_rx_router #(.NUM_VC(NUM_VC)) u_rx (
      .clk(clk), .rst_n(rst_n), .act_en(act_en), .top_ok(top_ok), .top_vc(top_vc),
      .rx_valid(rx_valid), .rx_vc(rx_vc), .rx_last(rx_last), .rx_ready(rx_ready),
      .hi_valid(hi_out_valid), .hi_ready(hi_out_ready),
      .lo_valid(lo_out_valid), .lo_ready(lo_out_ready),
      .rx_mid(rx_mid), .drop_err(rx_drop_err)
   );

   assign hi_out_data = rx_data;
   assign hi_out_last = rx_last;
   assign lo_out_data = rx_data;
   assign lo_out_last = rx_last;
   assign lo_out_vc   = rx_vc;

   vc_tx_arbiter #(.NUM_VC(NUM_VC), .ALLOW_RR(ALLOW_RR)) u_arb (
      .clk(clk), .rst_n(rst_n), .act_mode(act_mode), .top_ok(top_ok),
      .hi_vc(top_vc), .lo_vc(lo_tag), .hi_valid(hi_in_valid), .lo_valid(lo_in_valid),
      .tx_ready(tx_ready), .cur_lo(sel_lo), .cur_vc(tx_vc), .tx_valid(tx_valid),
      .hi_ready(hi_in_ready), .lo_ready(lo_in_ready), .tx_last(tx_last),
      .locked(tx_locked)
   );

   assign tx_data = sel_lo ? lo_in_data : hi_in_data;
   assign tx_last = sel_lo ? lo_in_last : hi_in_last;
endmodule

// File: rtl/vc_steer_arb_chk.sv
module vc_steer_arb_chk
   import vc_steer_pkg::*;
#(
   parameter int NUM_VC = 4,
   localparam int VC_W = $clog2(NUM_VC)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_VC-1:0] act_en,
   input arb_mode_e         act_mode,
   input logic [VC_W-1:0]   top_vc,
   input logic              tx_locked,
   input logic              rx_mid,
   input logic [VC_W-1:0]   rx_vc,
   input logic              hi_out_valid,
   input logic              lo_out_valid,
   input logic              rx_drop_err,
   input logic              hi_in_valid,
   input logic              hi_in_ready,
   input logic              lo_in_valid,
   input logic              lo_in_ready,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic              tx_last,
   input logic [VC_W-1:0]   tx_vc
);
   p_hi_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hi_out_valid |-> (act_en[rx_vc] && rx_vc == top_vc && !lo_out_valid));
   p_lo_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lo_out_valid |-> (act_en[rx_vc] && rx_vc != top_vc));
   p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_drop_err |=> rx_drop_err);
   p_hi_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_in_valid && hi_in_ready && !tx_locked) |-> (tx_vc == top_vc));
   p_lo_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_in_valid && lo_in_ready && $countones(act_en) > 1) |-> (tx_vc != top_vc));
   p_strict_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode == ARB_STRICT && !tx_locked && hi_in_valid && tx_ready && act_en != '0)
      |-> hi_in_ready);
   p_hold_vc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && !tx_last) |=> (tx_vc == $past(tx_vc)));
   p_one_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_in_ready && lo_in_ready));
   p_cfg_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_locked || rx_mid) |=> $stable(act_en));
   p_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (act_en == '0) |-> (!tx_valid && !hi_in_ready && !lo_in_ready));
endmodule

bind vc_steer_arb vc_steer_arb_chk #(.NUM_VC(NUM_VC)) u_chk (
   .clk(clk), .rst_n(rst_n), .act_en(act_en), .act_mode(act_mode), .top_vc(top_vc),
   .tx_locked(tx_locked), .rx_mid(rx_mid), .rx_vc(rx_vc),
   .hi_out_valid(hi_out_valid), .lo_out_valid(lo_out_valid), .rx_drop_err(rx_drop_err),
   .hi_in_valid(hi_in_valid), .hi_in_ready(hi_in_ready),
   .lo_in_valid(lo_in_valid), .lo_in_ready(lo_in_ready),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last), .tx_vc(tx_vc)
);

// File: tb/vc_steer_arb_tb.sv
module vc_steer_arb_tb;
   localparam int DW = 32;
   logic clk = 1'b0, rst_n = 1'b0;
   logic [3:0] cfg_vc_en = '0;
   logic cfg_rr_mode = 1'b0;
   logic rx_valid = 0, rx_last = 1, rx_ready;
   logic [1:0] rx_vc = '0;
   logic [DW-1:0] rx_data = '0;
   logic hi_out_valid, hi_out_ready = 1, hi_out_last;
   logic [DW-1:0] hi_out_data, lo_out_data, tx_data;
   logic lo_out_valid, lo_out_ready = 1, lo_out_last;
   logic [1:0] lo_out_vc, tx_vc;
   logic hi_in_valid = 0, hi_in_ready, hi_in_last = 1;
   logic lo_in_valid = 0, lo_in_ready, lo_in_last = 1;
   logic [DW-1:0] hi_in_data = 32'hAAAA_0000, lo_in_data = 32'h5555_0000;
   logic [1:0] lo_in_vc = '0;
   logic tx_valid, tx_ready = 1, tx_last, rx_drop_err;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   vc_steer_arb u_dut (.*);

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic set_cfg(input logic [3:0] m, input logic rr);
      @(negedge clk);
      cfg_vc_en = m; cfg_rr_mode = rr;
      @(negedge clk);
   endtask

   // {mask[3:0], vc[1:0], dest[1:0]}: dest 0 drop, 1 hi, 2 lo
   localparam logic [7:0] RX_TAB [0:7] = '{
      8'b1111_11_01, 8'b1111_01_10, 8'b1111_00_10, 8'b0101_10_01,
      8'b0101_11_00, 8'b0101_00_10, 8'b0011_10_00, 8'b0000_00_00 };
   // {mask[3:0], lo_req[1:0], exp_lo[1:0], exp_hi[1:0]}
   localparam logic [9:0] TX_TAB [0:6] = '{
      10'b1111_01_01_11, 10'b1111_11_10_11, 10'b1010_10_01_11, 10'b1010_01_01_11,
      10'b0110_00_01_10, 10'b0100_01_00_10, 10'b1001_11_00_11 };

   initial begin
      repeat (30000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [1:0] seq [4];
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 tx_valid", tx_valid, 0);
      chk("R12 hi_out_valid", hi_out_valid, 0);
      chk("R12 lo_out_valid", lo_out_valid, 0);
      chk("R12 rx_drop_err", rx_drop_err, 0);
      rst_n = 1'b1;

      // Receive routing table: R1, R2, R3
      for (int i = 0; i < 8; i++) begin
         set_cfg(RX_TAB[i][7:4], 1'b0);
         rx_vc = RX_TAB[i][3:2]; rx_data = 32'(i); rx_valid = 1'b1;
         #1;
         chk(RX_TAB[i][1:0] == 2'd1 ? "R1 hi_out_valid" : "R1/R2 hi_out_valid",
             hi_out_valid, RX_TAB[i][1:0] == 2'd1);
         chk("R2 lo_out_valid", lo_out_valid, RX_TAB[i][1:0] == 2'd2);
         if (RX_TAB[i][1:0] == 2'd2) chk("R2 lo_out_vc", lo_out_vc, RX_TAB[i][3:2]);
         if (RX_TAB[i][1:0] == 2'd1) chk("R1 hi_out_data", hi_out_data, 32'(i));
         chk("R3 rx_ready", rx_ready, 1);
         @(negedge clk);
         rx_valid = 1'b0;
         if (RX_TAB[i][1:0] == 2'd0) chk("R3 rx_drop_err set", rx_drop_err, 1);
      end
      @(negedge clk);
      chk("R3 rx_drop_err sticky", rx_drop_err, 1);

      // R4 backpressure independence
      set_cfg(4'b1111, 1'b0);
      lo_out_ready = 0; rx_vc = 2'd3; rx_valid = 1;
      #1 chk("R4 top VC ready with lo stalled", rx_ready, 1);
      rx_vc = 2'd1;
      #1 chk("R4 lo beat waits on lo_out_ready", rx_ready, 0);
      hi_out_ready = 0; lo_out_ready = 1;
      #1 chk("R4 lo beat ignores hi_out_ready", rx_ready, 1);
      rx_vc = 2'd3;
      #1 chk("R4 top beat follows hi_out_ready", rx_ready, 0);
      rx_valid = 0; hi_out_ready = 1;

      // Transmit tag table: R5, R6
      for (int i = 0; i < 7; i++) begin
         set_cfg(TX_TAB[i][9:6], 1'b0);
         hi_in_valid = 1; #1;
         chk("R5 hi tag", tx_vc, TX_TAB[i][1:0]);
         chk("R5 hi tx_valid", tx_valid, 1);
         @(negedge clk);
         hi_in_valid = 0; lo_in_valid = 1; lo_in_vc = TX_TAB[i][5:4]; #1;
         chk("R6 lo tag", tx_vc, TX_TAB[i][3:2]);
         chk("R6 lo data", tx_data, lo_in_data);
         @(negedge clk);
         lo_in_valid = 0;
      end

      // R7 strict priority
      set_cfg(4'b1111, 1'b0);
      hi_in_valid = 1; lo_in_valid = 1; lo_in_vc = 2'd1;
      for (int k = 0; k < 3; k++) begin
         #1;
         chk("R7 strict tag", tx_vc, 3);
         chk("R7 lo_in_ready low", lo_in_ready, 0);
         @(negedge clk);
      end
      hi_in_valid = 0; lo_in_valid = 0;

      // R8 round robin alternation
      set_cfg(4'b1111, 1'b1);
      hi_in_valid = 1; lo_in_valid = 1;
      for (int k = 0; k < 4; k++) begin
         #1 seq[k] = tx_vc;
         @(negedge clk);
      end
      hi_in_valid = 0; lo_in_valid = 0;
      chk("R8 rr grant 0", seq[0], 1);
      chk("R8 rr grant 1", seq[1], 3);
      chk("R8 rr grant 2", seq[2], 1);
      chk("R8 rr grant 3", seq[3], 3);

      // R9 packet hold and R10 config freeze
      set_cfg(4'b1111, 1'b0);
      lo_in_valid = 1; lo_in_vc = 2'd1; lo_in_last = 0;
      #1 chk("R9 lo first beat", tx_vc, 1);
      @(negedge clk);
      hi_in_valid = 1; cfg_vc_en = 4'b0011; #1;
      chk("R9 held on lo", tx_vc, 1);
      chk("R9 hi_in_ready low", hi_in_ready, 0);
      chk("R9 lo_in_ready high", lo_in_ready, 1);
      @(negedge clk);
      lo_in_last = 1; #1;
      chk("R10 tag kept mid-packet", tx_vc, 1);
      chk("R9 hi still blocked", hi_in_ready, 0);
      @(negedge clk);
      lo_in_valid = 0; #1;
      chk("R10 old mask one cycle after last", tx_vc, 3);
      chk("R9 hi granted after last", hi_in_ready, 1);
      @(negedge clk);
      #1 chk("R10 new mask applied", tx_vc, 1);
      @(negedge clk);
      hi_in_valid = 0;

      // R11 all-zero mask
      set_cfg(4'b0000, 1'b0);
      hi_in_valid = 1; lo_in_valid = 1; #1;
      chk("R11 tx_valid", tx_valid, 0);
      chk("R11 hi_in_ready", hi_in_ready, 0);
      chk("R11 lo_in_ready", lo_in_ready, 0);
      hi_in_valid = 0; lo_in_valid = 0;

      // R12 reset clears flag and pointer
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      chk("R12 flag cleared", rx_drop_err, 0);
      set_cfg(4'b1111, 1'b1);
      hi_in_valid = 1; lo_in_valid = 1; lo_in_vc = 2'd1; #1;
      chk("R12 rr pointer at VC 0", tx_vc, 1);
      @(negedge clk);
      hi_in_valid = 0; lo_in_valid = 0;

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule